// File: doc/BRIEF.md
# Macroblock pixel output sequencer

This block streams decoded pixels out of a local pixel buffer, one macroblock at a time. A start request carries the number of macroblocks in the frame. For each macroblock the block fetches samples from a synchronous buffer and presents them on a parallel data bus. Each sample is marked by a strobe that is high for two clocks and low for two clocks. A boundary signal stays high for the whole of each macroblock. A frame-ready flag is high from the first boundary rise of the frame to the last boundary fall.

All timing is fixed in clock cycles of the single system clock. The downstream converter can therefore latch a sample on the strobe's rising edge, with two clocks of stable data on each side. A request that arrives while a frame is still being sent is held and starts the next frame as soon as the current one ends. A request for zero macroblocks is dropped.

Top module: `mbpix_out_seq`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), rd_en_o, pix_vld_o, mb_bound_o and frame_rdy_o are 0 and pix_data_o is all zeros.
- R2: When the block is idle and frame_start_i is high with a nonzero mb_per_frame_i in clock cycle c, mb_bound_o and frame_rdy_o are both first high in cycle c+3.
- R3: Within each macroblock pix_vld_o pulses exactly MB_PIXELS times. Each pulse is high for 2 cycles and followed by 2 low cycles. The first pulse rises 2 cycles after mb_bound_o rises, and pix_vld_o is never high while mb_bound_o is low.
- R4: mb_bound_o stays high for 4*MB_PIXELS+2 cycles and falls 2 cycles after the last strobe pulse of the macroblock falls. Inside a frame it is then low for exactly 2 cycles before the next macroblock starts.
- R5: frame_rdy_o rises in the same cycle as the first mb_bound_o rise of a frame and falls in the same cycle as the fall at the end of macroblock number mb_per_frame_i (the count latched with the request).
- R6: For pixel k (0-based) of macroblock m (0-based within the frame), one single-cycle read is issued with rd_en_o high, rd_addr_o = k and rd_mb_o = m. This happens 4 cycles before that pixel's strobe rises, and rd_data_i must carry the sample in the cycle after the read. Reads are never in adjacent cycles.
- R7: pix_data_o shows pixel k's sample from 2 cycles before its strobe rises through the last cycle the strobe is high, four cycles in all.
- R8: A request with mb_per_frame_i equal to 0 is ignored. The outputs stay idle and no held request is cleared.
- R9: A nonzero request made while a frame is in progress is held. A later nonzero request replaces it. The held request starts in the cycle frame_rdy_o falls, so the new frame's frame_rdy_o rises 2 cycles later.
- R10: With frame_start_i held high continuously, frames follow one another with frame_rdy_o low for exactly 2 cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Frame request, sampled each clock |
| mb_per_frame_i | input | MBN_W | Macroblock count for the request |
| rd_en_o | output | 1 | Buffer read strobe |
| rd_addr_o | output | IDX_W | Pixel index within the macroblock |
| rd_mb_o | output | MBN_W | Macroblock index within the frame |
| rd_data_i | input | PIX_W | Buffer sample, valid the cycle after rd_en_o |
| pix_data_o | output | PIX_W | Output pixel sample |
| pix_vld_o | output | 1 | Pixel strobe, 2 high / 2 low per sample |
| mb_bound_o | output | 1 | High for the span of each macroblock |
| frame_rdy_o | output | 1 | High across a frame's output |

## Verification
The bench targets the hand-off between macroblocks and between frames. A slot counter that is off by one would stretch or shorten the boundary and move the 2-cycle gap. That shows up as a strobe outside the boundary or a frame-ready edge that no longer lines up with a boundary edge. Held requests are tested three ways: a zero-count request arriving after a real one, a newer request replacing an older one, and a request held high through several frame ends. A design that drops, merges or wrongly replaces a request sends frames of the wrong length. The data path is checked on every cycle of each four-cycle window. A fetch issued one cycle late, or a capture register that is missing, leaves the wrong sample on the bus before the strobe rises.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;

  // cycles between slot start and boundary rise (prefetch of pixel 0)
  localparam int unsigned PRE_CYC    = 2;
  // cycles between boundary rise and the first strobe rise
  localparam int unsigned LEAD_CYC   = 2;
  // strobe shape: high for STB_HI of every STB_PERIOD cycles
  localparam int unsigned STB_PERIOD = 4;
  localparam int unsigned STB_HI     = 2;

  // full length of one macroblock slot, prefetch cycles included
  function automatic int unsigned slot_len(input int unsigned pix);
    return PRE_CYC + LEAD_CYC + STB_PERIOD * pix;
  endfunction

  // boundary is high from the end of the prefetch to the end of the slot
  function automatic bit bound_on(input int unsigned p);
    return p >= PRE_CYC;
  endfunction

  function automatic bit strobe_on(input int unsigned p, input int unsigned pix);
    int unsigned first;
    first = PRE_CYC + LEAD_CYC;
    if (p < first || p >= first + STB_PERIOD * pix) return 1'b0;
    return ((p - first) % STB_PERIOD) < STB_HI;
  endfunction

  // a fetch at phase STB_PERIOD*k reaches the output register two cycles
  // later, which is two cycles ahead of the strobe rise for pixel k
  function automatic bit read_on(input int unsigned p, input int unsigned pix);
    return (p < STB_PERIOD * pix) && ((p % STB_PERIOD) == 0);
  endfunction

  function automatic int unsigned pix_index(input int unsigned p);
    return p / STB_PERIOD;
  endfunction

endpackage

// File: rtl/mbseq_slot_timer.sv
module mbseq_slot_timer
  import mbseq_pkg::*;
#(
  parameter int unsigned MB_PIXELS = 384,
  parameter int unsigned P_W       = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch_i,
  input  logic           busy_i,
  output logic [P_W-1:0] phase_o,
  output logic           slot_end_o,
  output logic           pre_phase_o
);

  localparam int unsigned SLOT_LEN = slot_len(MB_PIXELS);

  logic [P_W-1:0] phase_q;

  assign slot_end_o  = (phase_q == P_W'(SLOT_LEN - 1));
  assign pre_phase_o = (phase_q < P_W'(PRE_CYC));
  assign phase_o     = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (launch_i) begin
      phase_q <= '0;
    end else if (busy_i) begin
      phase_q <= slot_end_o ? '0 : phase_q + P_W'(1);
    end
  end

endmodule

// File: rtl/mbseq_frame_ctl.sv
module mbseq_frame_ctl #(
  parameter int unsigned MBN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic [MBN_W-1:0] mb_count_i,
  input  logic             slot_end_i,
  input  logic             pre_phase_i,
  output logic             busy_o,
  output logic             launch_o,
  output logic             last_slot_o,
  output logic             frame_rdy_o,
  output logic [MBN_W-1:0] mb_idx_o
);

  logic             busy_q;
  logic             pend_q;
  logic [MBN_W-1:0] total_q;
  logic [MBN_W-1:0] pend_total_q;
  logic [MBN_W-1:0] mb_q;
  logic             req_ok;
  logic             free_w;

  // zero-length requests never reach the frame logic
  assign req_ok      = frame_start_i && (mb_count_i != '0);
  assign last_slot_o = busy_q && slot_end_i && (mb_q == total_q - MBN_W'(1));
  assign free_w      = !busy_q || last_slot_o;
  assign launch_o    = free_w && (req_ok || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      pend_q       <= 1'b0;
      total_q      <= '0;
      pend_total_q <= '0;
      mb_q         <= '0;
    end else begin
      if (launch_o) begin
        busy_q  <= 1'b1;
        total_q <= req_ok ? mb_count_i : pend_total_q;
        mb_q    <= '0;
      end else if (last_slot_o) begin
        busy_q <= 1'b0;
      end else if (busy_q && slot_end_i) begin
        mb_q <= mb_q + MBN_W'(1);
      end

      // newest nonzero request wins while a frame is being sent
      if (launch_o) begin
        pend_q <= 1'b0;
      end else if (req_ok) begin
        pend_q       <= 1'b1;
        pend_total_q <= mb_count_i;
      end
    end
  end

  assign busy_o      = busy_q;
  assign mb_idx_o    = mb_q;
  assign frame_rdy_o = busy_q && !((mb_q == '0) && pre_phase_i);

endmodule

// File: rtl/mbseq_pixel_path.sv
module mbseq_pixel_path
  import mbseq_pkg::*;
#(
  parameter int unsigned MB_PIXELS = 384,
  parameter int unsigned PIX_W     = 8,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned P_W       = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic [P_W-1:0]   phase_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_addr_o,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic [PIX_W-1:0] pix_data_o,
  output logic             pix_vld_o,
  output logic             mb_bound_o
);

  logic [31:0]      phase32;
  logic             fetch_q;
  logic [PIX_W-1:0] pix_q;

  assign phase32    = 32'(phase_i);
  assign mb_bound_o = busy_i && bound_on(phase32);
  assign pix_vld_o  = busy_i && strobe_on(phase32, MB_PIXELS);
  assign rd_en_o    = busy_i && read_on(phase32, MB_PIXELS);
  assign rd_addr_o  = IDX_W'(pix_index(phase32));

  // the buffer answers one cycle after the read; the sample is held here
  // until the next answer arrives four cycles later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      fetch_q <= rd_en_o;
      if (fetch_q) pix_q <= rd_data_i;
    end
  end

  assign pix_data_o = pix_q;

endmodule

// File: rtl/mbpix_out_seq.sv
module mbpix_out_seq
  import mbseq_pkg::*;
#(
  parameter  int unsigned PIX_W     = 8,
  parameter  int unsigned MB_PIXELS = 384,
  parameter  int unsigned MBN_W     = 8,
  localparam int unsigned IDX_W     = (MB_PIXELS > 1) ? $clog2(MB_PIXELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic [MBN_W-1:0] mb_per_frame_i,
  output logic             rd_en_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic [MBN_W-1:0] rd_mb_o,
  input  logic [PIX_W-1:0] rd_data_i,
  output logic [PIX_W-1:0] pix_data_o,
  output logic             pix_vld_o,
  output logic             mb_bound_o,
  output logic             frame_rdy_o
);

  localparam int unsigned SLOT_LEN = slot_len(MB_PIXELS);
  localparam int unsigned P_W      = $clog2(SLOT_LEN);

  // internal events, named for the checker
  logic           busy_w;
  logic           launch_w;
  logic           slot_end_w;
  logic           last_slot_w;
  logic           pre_phase_w;
  logic [P_W-1:0] phase_w;

  mbseq_frame_ctl #(
    .MBN_W (MBN_W)
  ) frame_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start_i (frame_start_i),
    .mb_count_i    (mb_per_frame_i),
    .slot_end_i    (slot_end_w),
    .pre_phase_i   (pre_phase_w),
    .busy_o        (busy_w),
    .launch_o      (launch_w),
    .last_slot_o   (last_slot_w),
    .frame_rdy_o   (frame_rdy_o),
    .mb_idx_o      (rd_mb_o)
  );

  mbseq_slot_timer #(
    .MB_PIXELS (MB_PIXELS),
    .P_W       (P_W)
  ) timer_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch_w),
    .busy_i      (busy_w),
    .phase_o     (phase_w),
    .slot_end_o  (slot_end_w),
    .pre_phase_o (pre_phase_w)
  );

  mbseq_pixel_path #(
    .MB_PIXELS (MB_PIXELS),
    .PIX_W     (PIX_W),
    .IDX_W     (IDX_W),
    .P_W       (P_W)
  ) path_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_w),
    .phase_i    (phase_w),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .rd_data_i  (rd_data_i),
    .pix_data_o (pix_data_o),
    .pix_vld_o  (pix_vld_o),
    .mb_bound_o (mb_bound_o)
  );

endmodule

// File: rtl/mbpix_out_seq_chk.sv
module mbpix_out_seq_chk #(
  parameter int unsigned MBN_W = 8,
  parameter int unsigned PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start_i,
  input logic [MBN_W-1:0] mb_per_frame_i,
  input logic             busy_w,
  input logic             rd_en_o,
  input logic             pix_vld_o,
  input logic             mb_bound_o,
  input logic             frame_rdy_o,
  input logic [PIX_W-1:0] pix_data_o
);

  a_r3_strobe_inside: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_o |-> mb_bound_o);

  a_r3_first_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mb_bound_o) |=> !pix_vld_o ##1 pix_vld_o);

  a_r3_high_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_vld_o) |=> pix_vld_o);

  a_r3_high_max: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_o && $past(pix_vld_o)) |=> !pix_vld_o);

  a_r3_low_two: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pix_vld_o) && mb_bound_o) |=> !pix_vld_o);

  a_r4_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mb_bound_o) |-> (!$past(pix_vld_o) && !$past(pix_vld_o, 2) && $past(pix_vld_o, 3)));

  a_r5_rdy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_rdy_o) |-> $rose(mb_bound_o));

  a_r5_rdy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_rdy_o) |-> $fell(mb_bound_o));

  a_r6_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

  a_r7_hold_before: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_vld_o) |-> ($stable(pix_data_o) && ($past(pix_data_o) == $past(pix_data_o, 2))));

  a_r7_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_o && $past(pix_vld_o)) |-> $stable(pix_data_o));

  a_r8_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && frame_start_i && (mb_per_frame_i == '0)) |=> !busy_w);

endmodule

bind mbpix_out_seq mbpix_out_seq_chk #(
  .MBN_W (MBN_W),
  .PIX_W (PIX_W)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start_i  (frame_start_i),
  .mb_per_frame_i (mb_per_frame_i),
  .busy_w         (busy_w),
  .rd_en_o        (rd_en_o),
  .pix_vld_o      (pix_vld_o),
  .mb_bound_o     (mb_bound_o),
  .frame_rdy_o    (frame_rdy_o),
  .pix_data_o     (pix_data_o)
);

// File: tb/mbpix_out_seq_tb_top.sv
`timescale 1ns/1ps
module mbpix_out_seq_tb_top;

  localparam int NPIX = 384;
  localparam int SL   = 4 + 4 * NPIX;   // cycles per macroblock slot

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [7:0] mb_per_frame_i = 8'd0;
  logic       rd_en_o;
  logic [8:0] rd_addr_o;
  logic [7:0] rd_mb_o;
  logic [7:0] rd_data_i = 8'd0;
  logic [7:0] pix_data_o;
  logic       pix_vld_o;
  logic       mb_bound_o;
  logic       frame_rdy_o;

  always #2.5 clk = ~clk;

  mbpix_out_seq dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start_i  (frame_start_i),
    .mb_per_frame_i (mb_per_frame_i),
    .rd_en_o        (rd_en_o),
    .rd_addr_o      (rd_addr_o),
    .rd_mb_o        (rd_mb_o),
    .rd_data_i      (rd_data_i),
    .pix_data_o     (pix_data_o),
    .pix_vld_o      (pix_vld_o),
    .mb_bound_o     (mb_bound_o),
    .frame_rdy_o    (frame_rdy_o)
  );

  function automatic logic [7:0] fpix(input int mb, input int a);
    return 8'(mb * 53 + a * 7 + 11);
  endfunction

  // pixel buffer: one-cycle read latency
  always @(posedge clk) if (rd_en_o) rd_data_i <= fpix(int'(rd_mb_o), int'(rd_addr_o));

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    wd = 0;
  bit    m_act = 0;
  bit    m_pend = 0;
  int    m_s = 0;
  int    m_n = 0;
  int    m_pn = 0;
  string m_tag = "R5";
  bit    hold_mode = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // reference model: frame schedule in absolute cycle numbers
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_act = 0; m_pend = 0;
    end else begin
      cyc++;
      if (m_act && cyc == m_s + m_n * SL) m_act = 0;
      if (!m_act) begin
        if (frame_start_i && mb_per_frame_i != 0) begin
          m_act = 1; m_s = cyc; m_n = int'(mb_per_frame_i); m_pend = 0;
          m_tag = hold_mode ? "R10" : "R5";
        end else if (m_pend) begin
          m_act = 1; m_s = cyc; m_n = m_pn; m_pend = 0;
          m_tag = hold_mode ? "R10" : "R9";
        end
      end else if (frame_start_i && mb_per_frame_i != 0) begin
        m_pend = 1; m_pn = int'(mb_per_frame_i);
      end
    end
  end

  int  o, w, slot;
  bit  e_b, e_s, e_f, e_r;
  always @(negedge clk) begin
    if (rst_n) begin
      e_b = 0; e_s = 0; e_f = 0; e_r = 0;
      if (m_act) begin
        o = cyc - m_s; slot = o / SL; w = o % SL;
        e_b = (w >= 2);
        e_s = (w >= 4) && (((w - 4) % 4) < 2);
        e_f = (o >= 2);
        e_r = (w < 4 * NPIX) && ((w % 4) == 0);
        if (w >= 2 && w <= 4 * NPIX + 1)
          chk(pix_data_o == fpix(slot, (w - 2) / 4), "R7", pix_data_o, fpix(slot, (w - 2) / 4));
        if (e_r) begin
          chk(int'(rd_addr_o) == w / 4, "R6", rd_addr_o, w / 4);
          chk(int'(rd_mb_o) == slot, "R6", rd_mb_o, slot);
        end
      end
      chk(mb_bound_o == e_b, "R4", mb_bound_o, e_b);
      chk(pix_vld_o == e_s, "R3", pix_vld_o, e_s);
      chk(frame_rdy_o == e_f, m_tag, frame_rdy_o, e_f);
      chk(rd_en_o == e_r, "R6", rd_en_o, e_r);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected <150000 cycles", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic pulse(input int n);
    @(negedge clk); frame_start_i = 1'b1; mb_per_frame_i = 8'(n);
    @(negedge clk); frame_start_i = 1'b0;
  endtask

  // R2: launch from idle, first boundary in the third cycle after the request
  task automatic launch_idle(input int n);
    @(negedge clk); frame_start_i = 1'b1; mb_per_frame_i = 8'(n);
    @(negedge clk); frame_start_i = 1'b0;
    chk(mb_bound_o == 1'b0, "R2", mb_bound_o, 0);
    @(negedge clk);
    chk(mb_bound_o == 1'b0 && frame_rdy_o == 1'b0, "R2", mb_bound_o, 0);
    @(negedge clk);
    chk(mb_bound_o == 1'b1 && frame_rdy_o == 1'b1, "R2", mb_bound_o, 1);
  endtask

  task automatic wait_idle();
    while (m_act || m_pend) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_en_o == 0 && pix_vld_o == 0 && mb_bound_o == 0 && frame_rdy_o == 0,
        "R1", {rd_en_o, pix_vld_o, mb_bound_o, frame_rdy_o}, 0);
    chk(pix_data_o == 8'd0, "R1", pix_data_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: zero-count request at idle
    pulse(0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(mb_bound_o == 0 && rd_en_o == 0 && frame_rdy_o == 0, "R8",
          {mb_bound_o, rd_en_o, frame_rdy_o}, 0);
    end

    // single macroblock frame
    launch_idle(1);
    wait_idle();

    // R9: held request survives a zero-count request
    launch_idle(3);
    repeat (100) @(negedge clk);
    pulse(2);
    pulse(0);
    while (m_pend) @(negedge clk);
    // R9: newer request replaces an older held one
    repeat (100) @(negedge clk);
    pulse(3);
    pulse(1);
    wait_idle();

    // R10: request held high across frame ends
    hold_mode = 1'b1;
    @(negedge clk); frame_start_i = 1'b1; mb_per_frame_i = 8'd1;
    repeat (3 * SL) @(negedge clk);
    frame_start_i = 1'b0;
    wait_idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule